// File: doc/BRIEF.md
# PLL Startup and Calibration Sequencer

This block is the control sequencer for a clock synthesizer. It takes the synthesizer from power-on reset through a reference settling wait, runs a VCO calibration, and then waits for the loop to report lock before it declares the clocks ready. It also handles every later recalibration request and power-down request that arrives through the control bits or the external power-down pin. The oscillator, the VCO, the loop filter and the lock detector are outside the block. They appear only as input signals.

Delays are counted in two foreign clock domains: the settling wait in input-divider clock periods and the calibration in PFD clock periods. Each domain delivers a single-cycle tick that is synchronous to the system clock, and everything else runs on that one system clock. A mode bit selects how recalibration is requested. In mode 1, a rising edge on the calibration-enable bit recalibrates quickly with nothing powered down. In mode 0, the sleep bit and the power-down pin take the device through a full power-down, and the device calibrates on the way back up.

Top module: `pll_seq_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after it until `por_done_i` is high: `blk_pd_o`=1, and `cal_active_o`, `out_en_o`, `ready_o` and `reload_req_o` are 0.
- R2: After `por_done_i` rises, the block waits for exactly SETTLE_TICKS pulses of `ref_tick_i` and then raises `cal_active_o`. During this wait, `out_en_o`, `ready_o` and `blk_pd_o` are 0, and `pfd_tick_i` has no effect.
- R3: A calibration lasts exactly CAL_TICKS pulses of `pfd_tick_i`. `cal_active_o` falls in the cycle after the last counted pulse.
- R4: While `cal_active_o` is 1, `out_en_o`, `blk_pd_o` and `ready_o` are all 0.
- R5: After a calibration, `out_en_o` is 1 at once. `ready_o` stays 0 until `lock_i` is sampled high, and it rises one cycle later.
- R6: With `cal_mode_i`=1, a 0-to-1 edge of `cal_en_i` during calibration, lock wait or run starts a calibration in the next cycle. `ready_o` drops and `blk_pd_o` stays 0.
- R7: A `cal_en_i` rising edge that arrives while a mode-1 calibration is running restarts the count. After k counted ticks, the calibration then consumes k+CAL_TICKS ticks in total.
- R8: With `cal_mode_i`=1, transitions of `sleep_i` and `pd_pin_ni` have no effect. With `cal_mode_i`=0, edges of `cal_en_i` have no effect.
- R9: With `cal_mode_i`=0, a 1-to-0 edge of `sleep_i` sets `blk_pd_o`=1 and clears `out_en_o` and `ready_o`, and this holds for as long as `sleep_i` stays 0. A 0-to-1 edge of `sleep_i` then starts a calibration, with `reload_req_o` left at 0.
- R10: With `cal_mode_i`=0, `pd_pin_ni` going low is seen through a two-flop synchronizer and sets `blk_pd_o`=1. Its return high starts a calibration, and in the same cycle `reload_req_o` pulses high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| por_done_i | input | 1 | Power-on reset released and reference running |
| ref_tick_i | input | 1 | One-cycle tick per input-divider clock period |
| pfd_tick_i | input | 1 | One-cycle tick per PFD clock period |
| cal_mode_i | input | 1 | Recalibration mode: 1 = fast path, 0 = power-down path |
| cal_en_i | input | 1 | Calibration request bit; a rising edge acts in mode 1 |
| sleep_i | input | 1 | Sleep control bit; 0 = asleep in mode 0 |
| pd_pin_ni | input | 1 | Asynchronous power-down pin, active low |
| lock_i | input | 1 | PLL lock indication |
| cal_active_o | output | 1 | VCO calibration in progress |
| out_en_o | output | 1 | Clock outputs enabled |
| blk_pd_o | output | 1 | Device blocks powered down |
| reload_req_o | output | 1 | One-cycle request to reload nonvolatile registers |
| ready_o | output | 1 | PLL calibrated and locked |

## Verification
The settle and calibration counters are driven with sparse random tick patterns, which separates a correct tick-qualified count from one that advances on every clock. Noise on the other domain's tick shows that each counter listens only to its own. A restart at a random point inside a calibration tells a count that clears apart from one that keeps going. The same edges are applied in both modes, which shows that each trigger acts only in its own mode. Long random dwells in sleep and power-down, with toggling ticks and request bits, confirm that the held state cannot be disturbed. A pin return with a reload pulse is then distinguished from a sleep return without one.

// File: rtl/pll_seq_pkg.sv
`timescale 1ns/1ps
package pll_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_SETTLE = 3'd1,
    ST_CAL    = 3'd2,
    ST_LOCK   = 3'd3,
    ST_RUN    = 3'd4,
    ST_SLEEP  = 3'd5,
    ST_PDN    = 3'd6
  } seq_state_e;
endpackage

// File: rtl/pll_seq_sync.sv
`timescale 1ns/1ps
module pll_seq_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= RST_VAL;
        else         sr_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/pll_seq_edge.sv
`timescale 1ns/1ps
module pll_seq_edge #(
  parameter logic RISE    = 1'b1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= d_i;
  end

  generate
    if (RISE) begin : g_rise
      assign edge_o = d_i & ~prev_q;
    end else begin : g_fall
      assign edge_o = ~d_i & prev_q;
    end
  endgenerate
endmodule

// File: rtl/pll_seq_tick_cnt.sv
`timescale 1ns/1ps
module pll_seq_tick_cnt #(
  parameter int unsigned LIMIT = 550
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int unsigned W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;
  logic         step;

  assign step   = en_i & tick_i;
  assign done_o = step & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || done_o)   cnt_q <= '0;
    else if (step)              cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  p_cnt_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !step) |=> $stable(cnt_q));
endmodule

// File: rtl/pll_seq_ctrl.sv
`timescale 1ns/1ps
module pll_seq_ctrl
  import pll_seq_pkg::*;
#(
  parameter int unsigned SETTLE_TICKS = 16384,
  parameter int unsigned CAL_TICKS    = 550,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_done_i,
  input  logic ref_tick_i,
  input  logic pfd_tick_i,
  input  logic cal_mode_i,
  input  logic cal_en_i,
  input  logic sleep_i,
  input  logic pd_pin_ni,
  input  logic lock_i,
  output logic cal_active_o,
  output logic out_en_o,
  output logic blk_pd_o,
  output logic reload_req_o,
  output logic ready_o
);
  seq_state_e state_q, state_d;

  logic pd_sync;
  logic cal_en_rise, sleep_rise, sleep_fall, pd_rise, pd_fall;
  logic settle_done, cal_done;
  logic cal_restart, reload_d, reload_q;
  logic in_service;
  logic evt_pdn, evt_sleep, evt_cal;

  pll_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pd_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pd_pin_ni), .q_o(pd_sync));

  pll_seq_edge #(.RISE(1'b1), .RST_VAL(1'b0)) u_calen_rise (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cal_en_i), .edge_o(cal_en_rise));
  pll_seq_edge #(.RISE(1'b1), .RST_VAL(1'b1)) u_sleep_rise (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sleep_i), .edge_o(sleep_rise));
  pll_seq_edge #(.RISE(1'b0), .RST_VAL(1'b1)) u_sleep_fall (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sleep_i), .edge_o(sleep_fall));
  pll_seq_edge #(.RISE(1'b1), .RST_VAL(1'b1)) u_pd_rise (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pd_sync), .edge_o(pd_rise));
  pll_seq_edge #(.RISE(1'b0), .RST_VAL(1'b1)) u_pd_fall (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pd_sync), .edge_o(pd_fall));

  pll_seq_tick_cnt #(.LIMIT(SETTLE_TICKS)) u_settle_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(state_q != ST_SETTLE), .en_i(state_q == ST_SETTLE),
    .tick_i(ref_tick_i), .done_o(settle_done));

  pll_seq_tick_cnt #(.LIMIT(CAL_TICKS)) u_cal_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i((state_q != ST_CAL) || cal_restart), .en_i(state_q == ST_CAL),
    .tick_i(pfd_tick_i), .done_o(cal_done));

  assign in_service = (state_q == ST_CAL) || (state_q == ST_LOCK) || (state_q == ST_RUN);
  // priority: pin power-down, then sleep, then fast recalibration
  assign evt_pdn   = in_service && !cal_mode_i && pd_fall;
  assign evt_sleep = in_service && !cal_mode_i && sleep_fall;
  assign evt_cal   = in_service &&  cal_mode_i && cal_en_rise;

  assign cal_restart = (state_q == ST_CAL) && evt_cal && !evt_pdn && !evt_sleep;

  always_comb begin
    state_d  = state_q;
    reload_d = 1'b0;
    if (!por_done_i) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:    state_d = ST_SETTLE;
        ST_SETTLE: if (settle_done) state_d = ST_CAL;
        ST_CAL, ST_LOCK, ST_RUN: begin
          if (evt_pdn)        state_d = ST_PDN;
          else if (evt_sleep) state_d = ST_SLEEP;
          else if (evt_cal)   state_d = ST_CAL;
          else if (state_q == ST_CAL  && cal_done) state_d = ST_LOCK;
          else if (state_q == ST_LOCK && lock_i)   state_d = ST_RUN;
        end
        ST_SLEEP:  if (sleep_rise) state_d = ST_CAL;
        ST_PDN: begin
          if (pd_rise) begin
            state_d  = ST_CAL;
            reload_d = 1'b1;
          end
        end
        default:   state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_OFF;
      reload_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      reload_q <= reload_d;
    end
  end

  assign cal_active_o = (state_q == ST_CAL);
  assign out_en_o     = (state_q == ST_LOCK) || (state_q == ST_RUN);
  assign blk_pd_o     = (state_q == ST_OFF) || (state_q == ST_SLEEP) || (state_q == ST_PDN);
  assign ready_o      = (state_q == ST_RUN);
  assign reload_req_o = reload_q;

  p_ready_needs_lock_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(lock_i));

  p_cal_exit_on_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cal_active_o) && state_q == ST_LOCK) |-> $past(pfd_tick_i));

  p_reload_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_req_o |=> !reload_req_o);

  p_reload_with_cal_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_req_o |-> cal_active_o);

  p_sleep_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SLEEP && !sleep_i && por_done_i) |=> blk_pd_o && !out_en_o);

  p_mode1_no_pd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_service && cal_mode_i && por_done_i) |=> !blk_pd_o);

  p_settle_to_cal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cal_active_o) && $past(state_q) == ST_SETTLE) |-> $past(ref_tick_i));
endmodule

// File: tb/tb_pll_seq_ctrl.sv
`timescale 1ns/1ps
module tb_pll_seq_ctrl;
  localparam int SETTLE = 40;
  localparam int CALN   = 12;

  logic clk = 1'b0;
  logic rst_ni, por_done_i, ref_tick_i, pfd_tick_i, cal_mode_i, cal_en_i;
  logic sleep_i, pd_pin_ni, lock_i;
  logic cal_active_o, out_en_o, blk_pd_o, reload_req_o, ready_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  pll_seq_ctrl #(.SETTLE_TICKS(SETTLE), .CAL_TICKS(CALN)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .por_done_i(por_done_i),
    .ref_tick_i(ref_tick_i), .pfd_tick_i(pfd_tick_i),
    .cal_mode_i(cal_mode_i), .cal_en_i(cal_en_i), .sleep_i(sleep_i),
    .pd_pin_ni(pd_pin_ni), .lock_i(lock_i),
    .cal_active_o(cal_active_o), .out_en_o(out_en_o), .blk_pd_o(blk_pd_o),
    .reload_req_o(reload_req_o), .ready_o(ready_o));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int outs();
    return {27'd0, cal_active_o, out_en_o, blk_pd_o, reload_req_o, ready_o};
  endfunction

  // expected output vectors {cal,out_en,blk_pd,reload,ready}
  function automatic int exp_vec(input bit cal, input bit oe, input bit pd, input bit rl, input bit rdy);
    return {27'd0, cal, oe, pd, rl, rdy};
  endfunction

  function automatic bit rnd_tick();
    return ($urandom_range(0, 2) == 0);
  endfunction

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // counts ticks consumed while calibrating; optional restart after k ticks
  task automatic run_cal(input int restart_at, output int n, output bit bad);
    bit done_rs = 0;
    n = 0; bad = 0;
    forever begin
      if (!cal_active_o) break;
      if (out_en_o || blk_pd_o || ready_o) bad = 1;
      if (restart_at >= 0 && n == restart_at && !done_rs) begin
        pfd_tick_i = 1'b0;
        cal_en_i   = 1'b0;
        @(negedge clk);
        cal_en_i   = 1'b1;
        @(negedge clk);
        done_rs = 1;
        continue;
      end
      pfd_tick_i = rnd_tick();
      ref_tick_i = rnd_tick();
      if (pfd_tick_i) n++;
      @(negedge clk);
    end
    pfd_tick_i = 1'b0;
    ref_tick_i = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n, k, rl_cnt;
    bit bad, cal_seen;
    void'($urandom(32'd1234));
    rst_ni = 0; por_done_i = 0; ref_tick_i = 0; pfd_tick_i = 0;
    cal_mode_i = 1; cal_en_i = 0; sleep_i = 1; pd_pin_ni = 1; lock_i = 0;
    wait_n(3);
    chk("R1 in reset", outs(), exp_vec(0, 0, 1, 0, 0));
    rst_ni = 1;
    for (int i = 0; i < 6; i++) begin
      ref_tick_i = rnd_tick(); pfd_tick_i = rnd_tick();
      @(negedge clk);
    end
    ref_tick_i = 0; pfd_tick_i = 0;
    chk("R1 before por", outs(), exp_vec(0, 0, 1, 0, 0));

    // R2 settle count with pfd noise
    por_done_i = 1;
    @(negedge clk);
    n = 0; bad = 0;
    forever begin
      if (cal_active_o) break;
      if (out_en_o || ready_o || blk_pd_o) bad = 1;
      ref_tick_i = rnd_tick();
      pfd_tick_i = rnd_tick();
      if (ref_tick_i) n++;
      @(negedge clk);
    end
    ref_tick_i = 0; pfd_tick_i = 0;
    chk("R2 settle ticks", n, SETTLE);
    chk("R2 outputs off during settle", bad, 0);

    run_cal(-1, n, bad);
    chk("R3 cal ticks", n, CALN);
    chk("R4 outputs during cal", bad, 0);

    // R5 lock gating
    chk("R5 lock wait outputs", outs(), exp_vec(0, 1, 0, 0, 0));
    wait_n($urandom_range(3, 8));
    chk("R5 ready without lock", ready_o, 0);
    lock_i = 1;
    @(negedge clk);
    chk("R5 ready after lock", outs(), exp_vec(0, 1, 0, 0, 1));

    // R6 fast recal
    cal_en_i = 1;
    @(negedge clk);
    chk("R6 fast recal start", outs(), exp_vec(1, 0, 0, 0, 0));
    run_cal(-1, n, bad);
    chk("R6 fast recal ticks", n, CALN);
    chk("R6 no power-down during recal", bad, 0);

    // R7 restart during calibration (random rounds)
    for (int r = 0; r < 4; r++) begin
      wait_n(2);
      cal_en_i = 0; @(negedge clk);
      cal_en_i = 1; @(negedge clk);
      k = $urandom_range(1, CALN - 2);
      run_cal(k, n, bad);
      chk("R7 restart total ticks", n, k + CALN);
      chk("R7 outputs during restarted cal", bad, 0);
    end
    wait_n(2);
    chk("R7 ready after restart", ready_o, 1);

    // R8 mode 1 ignores sleep and pin
    sleep_i = 0; wait_n(6);
    chk("R8 mode1 sleep ignored", outs(), exp_vec(0, 1, 0, 0, 1));
    sleep_i = 1; wait_n(2);
    pd_pin_ni = 0; wait_n(6);
    chk("R8 mode1 pin low ignored", outs(), exp_vec(0, 1, 0, 0, 1));
    pd_pin_ni = 1; rl_cnt = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (reload_req_o) rl_cnt++; end
    chk("R8 mode1 pin return no reload", rl_cnt, 0);
    chk("R8 mode1 pin return no cal", outs(), exp_vec(0, 1, 0, 0, 1));

    // R8 mode 0 ignores cal_en
    cal_mode_i = 0;
    cal_en_i = 0; @(negedge clk);
    cal_en_i = 1; wait_n(3);
    chk("R8 mode0 cal_en ignored", outs(), exp_vec(0, 1, 0, 0, 1));

    // R9 sleep path
    sleep_i = 0; @(negedge clk);
    chk("R9 sleep entry", outs(), exp_vec(0, 0, 1, 0, 0));
    bad = 0;
    for (int i = 0; i < $urandom_range(8, 20); i++) begin
      ref_tick_i = rnd_tick(); pfd_tick_i = rnd_tick(); cal_en_i = rnd_tick();
      @(negedge clk);
      if (outs() != exp_vec(0, 0, 1, 0, 0)) bad = 1;
    end
    ref_tick_i = 0; pfd_tick_i = 0; cal_en_i = 0;
    chk("R9 sleep held", bad, 0);
    sleep_i = 1; @(negedge clk);
    chk("R9 wake starts cal without reload", outs(), exp_vec(1, 0, 0, 0, 0));
    run_cal(-1, n, bad);
    chk("R9 wake cal ticks", n, CALN);
    wait_n(2);
    chk("R9 ready after wake", ready_o, 1);

    // R10 pin power-down
    pd_pin_ni = 0; wait_n(4);
    chk("R10 pin power-down", outs(), exp_vec(0, 0, 1, 0, 0));
    wait_n(10);
    chk("R10 pin held down", blk_pd_o, 1);
    pd_pin_ni = 1; rl_cnt = 0; cal_seen = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (reload_req_o) begin rl_cnt++; if (!cal_active_o) cal_seen = 0; end
    end
    chk("R10 reload pulse count", rl_cnt, 1);
    chk("R10 reload with cal", cal_seen, 1);
    chk("R10 cal after pin return", cal_active_o, 1);
    run_cal(-1, n, bad);
    chk("R10 cal ticks after pin", n, CALN);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule